// File: doc/BRIEF.md
# Hex-Digit Floating-Point Add/Subtract Unit

This block adds or subtracts two floating-point words. Each word has a sign bit, a 7-bit exponent that stores the true power of sixteen plus 64, and a 24-bit fraction of six hexadecimal digits. The block picks the operand with the larger magnitude and finds the exponent gap to the other operand. It shifts the smaller fraction right by whole hex digits, keeping one extra guard digit. It then adds or subtracts the two magnitudes. It renormalizes the result one digit to the right, or as many digits to the left as needed, and drops the guard digit (truncation, no rounding). Overflow, underflow and a zero result are reported on separate flag pins.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream, with one register stage between them. The input is accepted on a clock edge where `in_valid` and `in_ready` are both high, and the result appears on `out_valid` after that edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and flags stay frozen and no new operands are taken. The flags are plain status bits that travel with the result.

Top module: `hexfp_addsub`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. An operand pair accepted at a clock edge produces `out_valid`=1 with its result right after that edge. While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and the result and flags hold their values.
- R2: Word layout is bit 31 sign (1 = negative), bits 30:24 exponent in excess-64, and bits 23:0 the fraction 0.d1..d6 in hex, with d1 in bits 23:20. An operand whose fraction is zero counts as zero, whatever its exponent field.
- R3: `in_sub`=1 gives a−b by flipping the sign of b, and `in_sub`=0 gives a+b. The block does a true addition or subtraction of magnitudes according to the signs that result.
- R4: The smaller-magnitude fraction is shifted right by d = exponent difference whole hex digits, and the result starts from the larger exponent. If d is 7 or more, the smaller operand adds nothing.
- R5: One guard digit keeps the first digit shifted out during alignment, so 0.100000×16^3 − 0.FFFFFF×16^2 gives exactly 0.100000×16^-3 (word 0x3D100000).
- R6: If the magnitude sum reaches 1, the result is shifted right one digit and the exponent goes up by one.
- R7: Leading zero digits of a difference are removed by a left shift of that many digits, and the exponent is lowered by the same count. Every nonzero result has a nonzero top digit.
- R8: The result sign is the sign of the operand with the larger magnitude, taken after the sign flip for subtraction.
- R9: Exact cancellation, or two zero operands, gives the all-zero word with `out_zero`=1.
- R10: If the exponent would go above 127, `out_ovf`=1 and the result is the largest magnitude (exponent and fraction all ones) with the result sign. Overflow and underflow are never both set.
- R11: If the exponent would go below 0, `out_unf`=1 and the result is the all-zero word with `out_zero`=1. An exponent of exactly 0 is a valid result.
- R12: The final fraction is the top six digits after normalization. The guard digit is dropped without rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is presented |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | 32 | First operand word |
| in_b | input | 32 | Second operand word |
| in_sub | input | 1 | 1 = a−b, 0 = a+b |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 32 | Normalized, truncated result word |
| out_ovf | output | 1 | Exponent overflow, result saturated |
| out_unf | output | 1 | Exponent underflow, result forced to zero |
| out_zero | output | 1 | Result is the zero word |

## Verification
The bench builds the block with its default parameters: a 7-bit exponent and six fraction digits. With these values both exponent limits can be reached with single operations: a carry at exponent 127 overflows, and a six-digit left shift near exponent 0 underflows. The boundary of the alignment cutoff is also checked, at a gap of six digits (guard digit only) and at seven digits (no contribution). The classic guard-digit subtraction, exact cancellation, and a stalled output with a second operand pair waiting are checked against hand-computed words.

// File: rtl/hexfp_pkg.sv
package hexfp_pkg;
  // Digits held beyond the fraction: one carry digit above, one guard digit below.
  localparam int unsigned CARRY_DIGITS = 1;
  localparam int unsigned GUARD_DIGITS = 1;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic zero;
  } hexfp_flags_t;
endpackage

// File: rtl/hexfp_align.sv
module hexfp_align #(
  parameter int unsigned EXP_W  = 7,
  parameter int unsigned DIGITS = 6
) (
  input  logic [EXP_W+4*DIGITS:0]                          op_a,
  input  logic [EXP_W+4*DIGITS:0]                          op_b,
  input  logic                                             sub,
  output logic [4*(DIGITS+hexfp_pkg::CARRY_DIGITS+hexfp_pkg::GUARD_DIGITS)-1:0] big_ext,
  output logic [4*(DIGITS+hexfp_pkg::CARRY_DIGITS+hexfp_pkg::GUARD_DIGITS)-1:0] small_al,
  output logic [EXP_W-1:0]                                 exp_big,
  output logic                                             sign_res,
  output logic                                             eff_sub
);
  localparam int unsigned FRAC_W = 4 * DIGITS;
  localparam int unsigned W      = 1 + EXP_W + FRAC_W;
  localparam int unsigned EXT_W  = 4 * (DIGITS + hexfp_pkg::CARRY_DIGITS + hexfp_pkg::GUARD_DIGITS);
  localparam int unsigned REACH  = DIGITS + hexfp_pkg::GUARD_DIGITS;

  logic              s_a, s_b, a_big;
  logic [EXP_W-1:0]  e_a, e_b, e_small, gap;
  logic [FRAC_W-1:0] f_a, f_b, f_big, f_small;
  logic [EXT_W-1:0]  small_ext;

  always_comb begin
    s_a = op_a[W-1];
    s_b = op_b[W-1] ^ sub;
    f_a = op_a[FRAC_W-1:0];
    f_b = op_b[FRAC_W-1:0];
    // a zero fraction means zero: its exponent field is ignored
    e_a = (f_a == '0) ? '0 : op_a[W-2:FRAC_W];
    e_b = (f_b == '0) ? '0 : op_b[W-2:FRAC_W];
    a_big   = {e_a, f_a} >= {e_b, f_b};
    exp_big = a_big ? e_a : e_b;
    e_small = a_big ? e_b : e_a;
    f_big   = a_big ? f_a : f_b;
    f_small = a_big ? f_b : f_a;
    sign_res = a_big ? s_a : s_b;
    eff_sub  = s_a ^ s_b;
    gap       = exp_big - e_small;
    big_ext   = {4'b0000, f_big, 4'b0000};
    small_ext = {4'b0000, f_small, 4'b0000};
    if (gap > EXP_W'(REACH)) small_al = '0;
    else                     small_al = small_ext >> {gap, 2'b00};
  end

  always_comb begin
    AST_ALIGN_ORDER: assert (big_ext >= small_al); // R4
  end
endmodule

// File: rtl/hexfp_norm.sv
module hexfp_norm #(
  parameter int unsigned EXP_W  = 7,
  parameter int unsigned DIGITS = 6
) (
  input  logic [4*(DIGITS+hexfp_pkg::CARRY_DIGITS+hexfp_pkg::GUARD_DIGITS)-1:0] sum,
  input  logic [EXP_W-1:0]              exp_big,
  input  logic                          sign_res,
  output logic [EXP_W+4*DIGITS:0]       res,
  output hexfp_pkg::hexfp_flags_t       flags
);
  localparam int unsigned FRAC_W = 4 * DIGITS;
  localparam int unsigned EXT_W  = 4 * (DIGITS + hexfp_pkg::CARRY_DIGITS + hexfp_pkg::GUARD_DIGITS);
  localparam int unsigned LOW_D  = DIGITS + hexfp_pkg::GUARD_DIGITS;

  logic [LOW_D-1:0] digit_nz;
  logic             carry;
  logic [EXP_W-1:0] lz;
  logic             found;
  logic [EXT_W-1:0] shifted;

  for (genvar i = 0; i < LOW_D; i++) begin : g_dig
    assign digit_nz[i] = |sum[4*i+3:4*i];
  end
  assign carry = |sum[EXT_W-1 -: 4];

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = LOW_D - 1; i >= 0; i--) begin
      if (!found) begin
        if (digit_nz[i]) found = 1'b1;
        else             lz    = lz + EXP_W'(1);
      end
    end
    shifted = sum << {lz, 2'b00};
  end

  always_comb begin
    res   = '0;
    flags = '0;
    if (sum == '0) begin
      flags.zero = 1'b1;
    end else if (carry) begin
      if (exp_big == '1) begin
        flags.ovf = 1'b1;
        res       = {sign_res, {(EXP_W + FRAC_W){1'b1}}};
      end else begin
        res = {sign_res, exp_big + EXP_W'(1), sum[EXT_W-1 -: FRAC_W]};
      end
    end else if (exp_big < lz) begin
      flags.unf  = 1'b1;
      flags.zero = 1'b1;
    end else begin
      res = {sign_res, exp_big - lz, shifted[EXT_W-5 -: FRAC_W]};
    end
  end

  always_comb begin
    AST_LEFT_SHIFT_BOUND: assert (sum == '0 || carry || lz < EXP_W'(LOW_D)); // R7
  end
endmodule

// File: rtl/hexfp_addsub.sv
module hexfp_addsub #(
  parameter int unsigned EXP_W  = 7,
  parameter int unsigned DIGITS = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [EXP_W+4*DIGITS:0] in_a,
  input  logic [EXP_W+4*DIGITS:0] in_b,
  input  logic                    in_sub,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [EXP_W+4*DIGITS:0] out_res,
  output logic                    out_ovf,
  output logic                    out_unf,
  output logic                    out_zero
);
  localparam int unsigned FRAC_W = 4 * DIGITS;
  localparam int unsigned W      = 1 + EXP_W + FRAC_W;
  localparam int unsigned EXT_W  = 4 * (DIGITS + hexfp_pkg::CARRY_DIGITS + hexfp_pkg::GUARD_DIGITS);

  logic [EXT_W-1:0]        big_ext, small_al, sum;
  logic [EXP_W-1:0]        exp_big;
  logic                    sign_res, eff_sub;
  logic [W-1:0]            res_c;
  hexfp_pkg::hexfp_flags_t flags_c;
  logic                    accept;

  hexfp_align #(.EXP_W(EXP_W), .DIGITS(DIGITS)) u_align (
    .op_a(in_a), .op_b(in_b), .sub(in_sub),
    .big_ext(big_ext), .small_al(small_al), .exp_big(exp_big),
    .sign_res(sign_res), .eff_sub(eff_sub)
  );

  // magnitudes are ordered, so the difference never goes negative
  assign sum = eff_sub ? (big_ext - small_al) : (big_ext + small_al);

  hexfp_norm #(.EXP_W(EXP_W), .DIGITS(DIGITS)) u_norm (
    .sum(sum), .exp_big(exp_big), .sign_res(sign_res),
    .res(res_c), .flags(flags_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
      out_zero  <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        out_res  <= res_c;
        out_ovf  <= flags_c.ovf;
        out_unf  <= flags_c.unf;
        out_zero <= flags_c.zero;
      end
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_zero)); // R1
  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_zero |-> out_res == '0); // R9
  AST_NORMALIZED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_zero |-> out_res[FRAC_W-1 -: 4] != 4'h0); // R7
  AST_SAT_ON_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> out_res[W-2:0] == '1); // R10
  AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_ovf, out_unf})); // R10
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unf |-> out_zero); // R11
endmodule

// File: tb/test_hexfp_addsub.sv
module test_hexfp_addsub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        in_sub = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_res;
  logic        out_ovf, out_unf, out_zero;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hexfp_addsub i_hexfp_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_ovf(out_ovf),
    .out_unf(out_unf), .out_zero(out_zero)
  );

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one operation, expected {valid, ovf, unf, zero, result}
  task automatic op(input string tag, input logic [31:0] a, input logic [31:0] b,
                    input logic sub, input logic [31:0] er, input logic [2:0] ef);
    @(negedge clk);
    in_a = a; in_b = b; in_sub = sub; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_valid, out_ovf, out_unf, out_zero, out_res}, {1'b1, ef, er});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset", {32'h0, 2'b00, out_valid, in_ready}, {32'h0, 2'b00, 1'b0, 1'b1});
  endtask

  task automatic t_add();
    op("R3 add equal exp", 32'h41200000, 32'h41300000, 1'b0, 32'h41500000, 3'b000);
    op("R3 add with negative b", 32'h41300000, 32'hC1100000, 1'b0, 32'h41200000, 3'b000);
    op("R2 zero fraction ignores exponent", 32'h55000000, 32'h41200000, 1'b0, 32'h41200000, 3'b000);
  endtask

  task automatic t_align();
    op("R4 gap of one digit", 32'h42100000, 32'h41100000, 1'b0, 32'h42110000, 3'b000);
    op("R4 gap six guard only", 32'h47100000, 32'h41FFFFFF, 1'b0, 32'h47100000, 3'b000);
    op("R4 gap seven no effect", 32'h48100000, 32'h41FFFFFF, 1'b0, 32'h48100000, 3'b000);
  endtask

  task automatic t_carry();
    op("R6 carry renormalize", 32'h41800000, 32'h41900000, 1'b0, 32'h42110000, 3'b000);
    op("R12 carry drops digit", 32'h41FFFFFF, 32'h41FFFFFF, 1'b0, 32'h421FFFFF, 3'b000);
    op("R12 guard truncated", 32'h42100000, 32'h41FFFFFF, 1'b0, 32'h421FFFFF, 3'b000);
  endtask

  task automatic t_sub();
    op("R5 guard digit subtraction", 32'h43100000, 32'h42FFFFFF, 1'b1, 32'h3D100000, 3'b000);
    op("R7 two leading zeros", 32'h41123456, 32'h41120000, 1'b1, 32'h3F345600, 3'b000);
    op("R8 sign of larger", 32'h41100000, 32'h41300000, 1'b1, 32'hC1200000, 3'b000);
    op("R9 exact cancel", 32'h45123456, 32'h45123456, 1'b1, 32'h00000000, 3'b001);
    op("R9 opposite signs cancel", 32'hC5123456, 32'h45123456, 1'b0, 32'h00000000, 3'b001);
  endtask

  task automatic t_range();
    op("R10 positive overflow", 32'h7F800000, 32'h7F800000, 1'b0, 32'h7FFFFFFF, 3'b100);
    op("R10 negative overflow", 32'hFF800000, 32'hFF800000, 1'b0, 32'hFFFFFFFF, 3'b100);
    op("R11 underflow", 32'h02100000, 32'h01FFFFFF, 1'b1, 32'h00000000, 3'b011);
    op("R11 exponent zero valid", 32'h06100000, 32'h05FFFFFF, 1'b1, 32'h00100000, 3'b000);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    in_a = 32'h41200000; in_b = 32'h41300000; in_sub = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 stalled first", {out_valid, in_ready, 2'b00, out_res}, {1'b1, 1'b0, 2'b00, 32'h41500000});
    in_a = 32'h42100000; in_b = 32'h41100000;
    @(posedge clk);
    @(negedge clk);
    check("R1 held under stall", {out_valid, in_ready, 2'b00, out_res}, {1'b1, 1'b0, 2'b00, 32'h41500000});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 second after release", {out_valid, 3'b000, out_res}, {1'b1, 3'b000, 32'h42110000});
    @(posedge clk);
    @(negedge clk);
    check("R1 drained", {35'h0, out_valid}, {35'h0, 1'b0});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add();
    t_align();
    t_carry();
    t_sub();
    t_range();
    t_stall();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule